// File: doc/BRIEF.md
# Half-Bridge Leg Gate Guard

This block is the output-side logic for one leg of a half-bridge inverter. It receives the active-low commands for the upper and lower switch after they have been filtered. It turns them into active-high gate enables for the two switches. Asking for both switches at once switches both off. A gate may turn on after the opposite gate turns off only when both gates have been off for at least `DEAD_CYC` clock cycles. If the controller already leaves a gap that long, the gap is passed through as commanded.

A shutdown request turns both gates off on the next clock edge. A flag reporting low supply on the upper switch's floating rail turns only the upper gate off. After that flag clears, the upper gate stays off until the controller gives a new activating (high-to-low) edge on the upper command. A three-phase driver uses three instances of this block, one per leg, and ties the shutdown input of all three together. Both gate enables are registered, so each follows its command with one cycle of latency. `DEAD_CYC` must be 1 or more; at 200 MHz the default of 55 cycles is 275 ns.

Top module: `leg_gate_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `hs_gate` and `ls_gate` are 0.
- R2: Decoding, seen one clock edge later: `hi_cmd_n`=0 with `lo_cmd_n`=1 asks for the upper gate. `lo_cmd_n`=0 with `hi_cmd_n`=1 asks for the lower gate. Both at 1 or both at 0 turn both gates off.
- R3: `hs_gate` and `ls_gate` are never 1 in the same cycle.
- R4: A gate turns on after the opposite gate was last on only when both gates have been 0 for at least `DEAD_CYC` consecutive cycles. If the commanded gap is shorter, the turn-on is held back until the gap equals exactly `DEAD_CYC` cycles.
- R5: If both commands stay inactive for `DEAD_CYC` cycles or more between opposite turn-ons, each gate equals its decoded command delayed by one cycle, with no added delay.
- R6: A gate turning on again when it was itself the last gate on is not held back by the deadtime.
- R7: The deadtime is the same for the upper-to-lower change and the lower-to-upper change.
- R8: When `shutdown`=1, both gates are 0 from the next cycle on for as long as it stays 1. After it is released, the gates again follow R2 to R6.
- R9: When `hs_uv`=1, `hs_gate` is 0 from the next cycle on, and `ls_gate` still follows its command.
- R10: After `hs_uv` returns to 0, `hs_gate` stays 0 until `hi_cmd_n` is seen changing from 1 to 0 while `hs_uv` is 0. The upper gate may turn on one cycle after that edge.
- R11: Out of reset, the upper gate is enabled (no edge is needed) and the deadtime counts as already expired, so the first command is followed after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_cmd_n | input | 1 | Upper switch command, active low, already filtered |
| lo_cmd_n | input | 1 | Lower switch command, active low, already filtered |
| shutdown | input | 1 | Global shutdown request, active high |
| hs_uv | input | 1 | Upper floating supply undervoltage flag, active high |
| hs_gate | output | 1 | Upper gate enable, active high |
| ls_gate | output | 1 | Lower gate enable, active high |

## Verification
The assertions check on every cycle that the two gates never overlap. They also check that every opposite turn-on comes after at least `DEAD_CYC` off cycles, counted by a separate checker counter. They further check that both-active commands, shutdown and the undervoltage flag force the gates they guard to 0, and that the upper gate stays off after undervoltage until a new edge. Other behaviour can only be seen by comparing each cycle against the bench's reference model in specific scenarios. That includes the exact gap of `DEAD_CYC` cycles when the commanded gap is too short, and gaps of `DEAD_CYC` or more passing through unchanged. It also includes same-side re-enabling with no delay, the equal gap in both directions, and the immediate first turn-on after reset.

// File: rtl/leg_guard_pkg.sv
package leg_guard_pkg;
    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HI   = 2'd1,
        SIDE_LO   = 2'd2
    } side_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;
endpackage

// File: rtl/leg_cmd_decode.sv
module leg_cmd_decode (
    input  logic hi_cmd_n,
    input  logic lo_cmd_n,
    output logic want_hi,
    output logic want_lo
);
    // exactly one command active selects a side; none or both selects nothing
    always_comb begin
        want_hi = ~hi_cmd_n & lo_cmd_n;
        want_lo = ~lo_cmd_n & hi_cmd_n;
    end
endmodule

// File: rtl/leg_hs_rearm.sv
module leg_hs_rearm (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd_n,
    input  logic hs_uv,
    output logic hs_permit
);
    typedef struct packed {
        logic armed;
        logic prev_n;
    } rearm_t;

    rearm_t st_d, st_q;
    logic   fall_edge;

    always_comb begin
        fall_edge    = st_q.prev_n & ~hi_cmd_n;
        hs_permit    = ~hs_uv & (st_q.armed | fall_edge);
        st_d.armed   = hs_permit;
        st_d.prev_n  = hi_cmd_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.armed  <= 1'b1;
            st_q.prev_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: once disarmed, only an activating edge re-arms
    assert_rearm_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.armed && !(st_q.prev_n && !hi_cmd_n)) |=> !st_q.armed);
endmodule

// File: rtl/leg_dead_timer.sv
module leg_dead_timer
    import leg_guard_pkg::*;
#(
    parameter int DEAD_CYC = 55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nxt_hi,
    input  logic nxt_lo,
    output logic hi_ok,
    output logic lo_ok
);
    localparam int CNT_W = $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] DEAD_V = CNT_W'(DEAD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] off_cnt;
        side_e            last;
    } timer_t;

    timer_t st_d, st_q;
    logic   gap_done;

    always_comb begin
        gap_done = (st_q.off_cnt >= DEAD_V);
        hi_ok    = gap_done | (st_q.last == SIDE_HI);
        lo_ok    = gap_done | (st_q.last == SIDE_LO);

        st_d = st_q;
        if (nxt_hi | nxt_lo) begin
            st_d.off_cnt = '0;
        end else if (!gap_done) begin
            st_d.off_cnt = st_q.off_cnt + 1'b1;
        end
        if (nxt_hi) begin
            st_d.last = SIDE_HI;
        end else if (nxt_lo) begin
            st_d.last = SIDE_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.off_cnt <= DEAD_V;
            st_q.last    <= SIDE_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the off counter never exceeds its saturation value
    assert_cnt_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.off_cnt <= DEAD_V);
endmodule

// File: rtl/leg_gate_guard.sv
module leg_gate_guard
    import leg_guard_pkg::*;
#(
    parameter int DEAD_CYC = 55
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd_n,
    input  logic lo_cmd_n,
    input  logic shutdown,
    input  logic hs_uv,
    output logic hs_gate,
    output logic ls_gate
);
    localparam int CHK_W = $clog2(DEAD_CYC + 1);
    localparam logic [CHK_W-1:0] CHK_MAX = CHK_W'(DEAD_CYC);

    gate_pair_t g_d, g_q;
    logic want_hi, want_lo, hs_permit, hi_ok, lo_ok;

    leg_cmd_decode u_decode (
        .hi_cmd_n (hi_cmd_n),
        .lo_cmd_n (lo_cmd_n),
        .want_hi  (want_hi),
        .want_lo  (want_lo)
    );

    leg_hs_rearm u_rearm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_cmd_n  (hi_cmd_n),
        .hs_uv     (hs_uv),
        .hs_permit (hs_permit)
    );

    leg_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_hi (g_d.hs),
        .nxt_lo (g_d.ls),
        .hi_ok  (hi_ok),
        .lo_ok  (lo_ok)
    );

    always_comb begin
        g_d.hs = want_hi & ~shutdown & hs_permit & hi_ok;
        g_d.ls = want_lo & ~shutdown & lo_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '0;
        end else begin
            g_q <= g_d;
        end
    end

    assign hs_gate = g_q.hs;
    assign ls_gate = g_q.ls;

    // ---------------- checker state (independent off-gap count) ----------------
    logic [CHK_W-1:0] chk_off_q;
    side_e            chk_last_q;
    logic             chk_need_edge_q;
    logic             chk_prev_n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_off_q       <= CHK_MAX;
            chk_last_q      <= SIDE_NONE;
            chk_need_edge_q <= 1'b0;
            chk_prev_n_q    <= 1'b1;
        end else begin
            if (g_q.hs || g_q.ls)        chk_off_q <= '0;
            else if (chk_off_q < CHK_MAX) chk_off_q <= chk_off_q + 1'b1;
            if (g_q.hs)      chk_last_q <= SIDE_HI;
            else if (g_q.ls) chk_last_q <= SIDE_LO;
            if (hs_uv)                                   chk_need_edge_q <= 1'b1;
            else if (chk_prev_n_q && !hi_cmd_n)          chk_need_edge_q <= 1'b0;
            chk_prev_n_q <= hi_cmd_n;
        end
    end

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    assert_gap_lo_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_gate) && chk_last_q == SIDE_HI) |-> (chk_off_q >= CHK_MAX));

    assert_gap_hi_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_gate) && chk_last_q == SIDE_LO) |-> (chk_off_q >= CHK_MAX));

    assert_both_cmd_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_cmd_n && !lo_cmd_n) |=> (!hs_gate && !ls_gate));

    assert_shutdown_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (!hs_gate && !ls_gate));

    assert_uv_hs_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_uv |=> !hs_gate);

    assert_uv_needs_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_need_edge_q && !(chk_prev_n_q && !hi_cmd_n && !hs_uv)) |=> !hs_gate);
endmodule

// File: tb/leg_gate_guard_bench.sv
module leg_gate_guard_bench;
    localparam int DT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd_n = 1'b1, lo_cmd_n = 1'b1, shutdown = 1'b0, hs_uv = 1'b0;
    logic hs_gate, ls_gate;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_hs = 0, m_ls = 0, m_arm = 1, m_prevh = 1;
    int m_off = 1000;
    int m_last = 0; // 0 none, 1 upper, 2 lower

    always #2.5 clk = ~clk;

    leg_gate_guard #(.DEAD_CYC(DT)) u_leg_gate_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_cmd_n (hi_cmd_n),
        .lo_cmd_n (lo_cmd_n),
        .shutdown (shutdown),
        .hs_uv    (hs_uv),
        .hs_gate  (hs_gate),
        .ls_gate  (ls_gate)
    );

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void model_step(input bit h_n, input bit l_n, input bit sd, input bit uv);
        bit wh, wl, fall, perm, nh, nl;
        wh   = !h_n && l_n;
        wl   = !l_n && h_n;
        fall = m_prevh && !h_n;
        perm = !uv && (m_arm || fall);
        nh   = wh && !sd && perm && (m_off >= DT || m_last == 1);
        nl   = wl && !sd && (m_off >= DT || m_last == 2);
        m_arm   = perm;
        m_prevh = h_n;
        if (nh) m_last = 1;
        else if (nl) m_last = 2;
        m_off = (nh || nl) ? 0 : m_off + 1;
        m_hs = nh;
        m_ls = nl;
    endfunction

    // one clock: drive at negedge, model at posedge, compare just after
    task automatic cyc(input bit h_n, input bit l_n, input bit sd, input bit uv);
        @(negedge clk);
        hi_cmd_n = h_n; lo_cmd_n = l_n; shutdown = sd; hs_uv = uv;
        @(posedge clk);
        model_step(h_n, l_n, sd, uv);
        #1;
        check_bit(cur_req, "hs_gate", hs_gate, m_hs);
        check_bit(cur_req, "ls_gate", ls_gate, m_ls);
        check_bit("R3", "overlap", hs_gate & ls_gate, 1'b0);
    endtask

    task automatic run(input bit h_n, input bit l_n, input bit sd, input bit uv, input int n);
        for (int i = 0; i < n; i++) cyc(h_n, l_n, sd, uv);
    endtask

    // switch command directly to the opposite side and count cycles to its turn-on
    task automatic measure_switch(input string req, input bit to_lo, input int exp_cycles);
        int n;
        n = 0;
        for (int i = 0; i < 4 * DT; i++) begin
            if (to_lo) cyc(1'b1, 1'b0, 1'b0, 1'b0);
            else       cyc(1'b0, 1'b1, 1'b0, 1'b0);
            n++;
            if ((to_lo && ls_gate) || (!to_lo && hs_gate)) break;
        end
        check_int(req, "cycles to opposite turn-on", n, exp_cycles);
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check_bit("R1", "hs_gate in reset", hs_gate, 1'b0);
            check_bit("R1", "ls_gate in reset", ls_gate, 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        cur_req = "R1";
        cyc(1, 1, 0, 0);

        cur_req = "R11";
        cyc(0, 1, 0, 0);
        check_bit("R11", "first turn-on after reset", hs_gate, 1'b1);

        cur_req = "R2";
        run(0, 1, 0, 0, 6);
        run(0, 0, 0, 0, 4);
        check_bit("R2", "both active blocks", hs_gate | ls_gate, 1'b0);
        run(1, 1, 0, 0, 3);
        cur_req = "R4";
        run(1, 0, 0, 0, 12);

        measure_switch("R4", 1'b0, DT + 1);
        run(0, 1, 0, 0, 5);
        cur_req = "R7";
        measure_switch("R7", 1'b1, DT + 1);
        run(1, 0, 0, 0, 4);

        cur_req = "R5";
        run(1, 1, 0, 0, DT + 4);
        cyc(0, 1, 0, 0);
        check_bit("R5", "long gap not stretched", hs_gate, 1'b1);
        run(0, 1, 0, 0, 5);
        run(1, 1, 0, 0, DT);
        cyc(1, 0, 0, 0);
        check_bit("R5", "gap equal to deadtime not stretched", ls_gate, 1'b1);
        run(1, 0, 0, 0, 4);

        cur_req = "R6";
        run(1, 1, 0, 0, 2);
        cyc(1, 0, 0, 0);
        check_bit("R6", "same side re-on immediate", ls_gate, 1'b1);
        run(1, 0, 0, 0, 3);
        run(0, 0, 0, 0, 1);
        cyc(1, 0, 0, 0);
        check_bit("R6", "re-on after both-active gap", ls_gate, 1'b1);

        cur_req = "R8";
        run(1, 1, 0, 0, DT);
        run(0, 1, 0, 0, 5);
        cyc(0, 1, 1, 0);
        check_bit("R8", "shutdown forces upper off", hs_gate, 1'b0);
        run(0, 1, 1, 0, 3);
        cyc(0, 1, 0, 0);
        check_bit("R8", "resume after shutdown", hs_gate, 1'b1);
        run(0, 1, 0, 0, 3);
        run(1, 0, 1, 0, 3);
        run(1, 0, 0, 0, DT + 3);

        cur_req = "R9";
        run(1, 0, 0, 1, 4);
        check_bit("R9", "lower unaffected by undervoltage", ls_gate, 1'b1);
        run(1, 1, 0, 1, DT + 2);
        run(0, 1, 0, 1, 5);
        check_bit("R9", "upper held off in undervoltage", hs_gate, 1'b0);

        cur_req = "R10";
        run(0, 1, 0, 0, 6);
        check_bit("R10", "upper off without new edge", hs_gate, 1'b0);
        cyc(1, 1, 0, 0);
        cyc(0, 1, 0, 0);
        check_bit("R10", "upper on after fresh edge", hs_gate, 1'b1);
        run(0, 1, 0, 0, 3);
        cyc(0, 1, 0, 1);
        check_bit("R9", "undervoltage while on", hs_gate, 1'b0);
        run(0, 1, 0, 1, 2);
        run(0, 1, 0, 0, 4);
        run(1, 1, 0, 0, 1);
        run(0, 1, 0, 0, 3);

        cur_req = "R3";
        for (int k = 0; k < 40; k++) begin
            cyc(k[0], k[1] ^ k[3], 1'b0, 1'b0);
        end
        run(1, 1, 0, 0, DT + 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule